// File: doc/BRIEF.md
# Glitch-Free Clock Source Mux

This block chooses which of two clocks reaches a single output clock: an always-running reference clock, or the output of a fractional M/N divider. The two clocks are unrelated to each other. It moves from one to the other without producing a shortened high or low phase. Each source has its own gating path. A path shuts its gate only on its own falling edge, after a two-flop synchronizer. The other path opens its gate only after it has seen, through its own synchronizer, that the first gate is shut.

The select bit is held in a small control stage that runs on the system clock. It can be set in four ways: from bit 10 of a control word write, from enable and disable requests, or by a reprogramming bracket. While the M/N divider is being reprogrammed, the control stage parks the output on the reference clock. When reprogramming ends, the select returns to the M/N side only if the clock is currently enabled.

If the M/N clock has stopped, a handoff to it cannot complete. The output then stays low, and the status output keeps naming the old source. Selecting the reference again recovers the output.

Top module: `gcm_top`

## Requirements
- R1: After reset, `sel_req` is 0 and, once the handoff settles, `src_live` is 0 (reference) and `clk_out` follows `ref_clk`.
- R2: Outside reprogramming, `en_req` makes `sel_req` 1 one system cycle later. `dis_req` makes it 0 one cycle later. When both are high in the same cycle, `dis_req` wins.
- R3: `reprog_start` makes `sel_req` 0 one cycle later. `sel_req` then stays 0 until `reprog_done`, whatever `en_req` or `ns_wr` do in between.
- R4: On `reprog_done`, `sel_req` becomes 1 one cycle later if the most recent enable/disable request was an enable. Otherwise it becomes 0. A disable issued during reprogramming counts as the most recent request.
- R5: Outside reprogramming, and with no enable or disable request in the same cycle, `ns_wr` loads `sel_req` from `ns_wdata[10]` (1 = M/N clock, 0 = reference). No other bit of the word has any effect.
- R6: A source's gate opens only after the other gate is shut. The two gates are never open at once, and after each switch `src_live` names the selected source.
- R7: `src_live` (0 = reference, 1 = M/N) changes only after the new source's gate is open. If the selected source is not toggling, `src_live` keeps its old value and `clk_out` stays low.
- R8: Across repeated switches, no high or low phase of `clk_out` is shorter than the shorter half-period of the two sources.
- R9: After a stuck handoff, selecting the reference restores a toggling `clk_out` with `src_live` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Control and status clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_clk | input | 1 | Always-running reference clock |
| mn_clk | input | 1 | M/N divider output clock |
| ns_wr | input | 1 | Control word write strobe |
| ns_wdata | input | NS_W | Control word; bit SEL_BIT picks the source |
| en_req | input | 1 | Clock enable request (select M/N) |
| dis_req | input | 1 | Clock disable request (select reference) |
| reprog_start | input | 1 | M/N reprogramming begins |
| reprog_done | input | 1 | M/N reprogramming ends |
| sel_req | output | 1 | Requested source, 1 = M/N |
| src_live | output | 1 | Source actually driving the output, 1 = M/N |
| clk_out | output | 1 | Muxed output clock |

## Verification
The assertions assume that the control pulses are synchronous to `sys_clk`. They also assume that the two source clocks stay far enough apart in time for each handoff to finish before the select changes again. Mutual exclusion of the gates, and the absence of runt phases, both depend on that spacing. The stimulus drives every control input on the falling edge of `sys_clk`. It leaves at least 40 system cycles between switches, which covers the worst-case synchronizer latency on both sides. It stops the M/N clock only while it is low and deselected, so that stopping the clock cannot itself cut a phase short.

// File: rtl/gcm_pkg.sv
package gcm_pkg;

  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_MN  = 1'b1
  } gcm_src_e;

  typedef struct packed {
    logic start;
    logic done;
    logic en;
    logic dis;
    logic wr;
    logic wbit;
  } gcm_cmd_t;

  // enable/disable bookkeeping: disable has priority
  function automatic logic gcm_enabled_next(logic cur, gcm_cmd_t c);
    if (c.dis)     return 1'b0;
    else if (c.en) return 1'b1;
    else           return cur;
  endfunction

  function automatic logic gcm_busy_next(logic cur, gcm_cmd_t c);
    if (c.start)     return 1'b1;
    else if (c.done) return 1'b0;
    else             return cur;
  endfunction

  // select priority: start > end of reprogram > parked > dis > en > write
  function automatic logic gcm_sel_next(logic cur, logic busy, logic en_nxt,
                                        gcm_cmd_t c);
    if (c.start)             return SRC_REF;
    else if (busy && c.done) return en_nxt;
    else if (busy)           return SRC_REF;
    else if (c.dis)          return SRC_REF;
    else if (c.en)           return SRC_MN;
    else if (c.wr)           return c.wbit;
    else                     return cur;
  endfunction

endpackage

// File: rtl/gcm_sync.sv
module gcm_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gcm_rst_sync.sv
module gcm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain[STAGES-1];
endmodule

// File: rtl/gcm_leg.sv
module gcm_leg #(
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic arst_n,
  input  logic pick,
  input  logic peer_on,
  output logic gate_on
);
  logic src_rst_n;
  logic want;
  logic want_s;

  gcm_rst_sync #(.STAGES(STAGES)) u_rst (
    .clk     (src_clk),
    .arst_n  (arst_n),
    .rst_n_o (src_rst_n)
  );

  // open only while picked and the other path reports its gate shut
  assign want = pick & ~peer_on;

  gcm_sync #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_want (
    .clk   (src_clk),
    .rst_n (src_rst_n),
    .d     (want),
    .q     (want_s)
  );

  // gate moves only while the source is low
  always_ff @(negedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) gate_on <= 1'b0;
    else            gate_on <= want_s;
  end
endmodule

// File: rtl/gcm_ctrl.sv
module gcm_ctrl
  import gcm_pkg::*;
#(
  parameter int NS_W    = 32,
  parameter int SEL_BIT = 10
) (
  input  logic            sys_clk,
  input  logic            rst_n,
  input  logic            ns_wr,
  input  logic [NS_W-1:0] ns_wdata,
  input  logic            en_req,
  input  logic            dis_req,
  input  logic            reprog_start,
  input  logic            reprog_done,
  output logic            sel_req
);
  gcm_cmd_t cmd;
  logic     enabled_q, busy_q;
  logic     enabled_d, busy_d, sel_d;
  logic     unused_ns_bits;

  assign cmd = '{start: reprog_start, done: reprog_done, en: en_req,
                 dis: dis_req, wr: ns_wr, wbit: ns_wdata[SEL_BIT]};
  assign unused_ns_bits = ^{ns_wdata[NS_W-1:SEL_BIT+1], ns_wdata[SEL_BIT-1:0]};

  always_comb begin
    enabled_d = gcm_enabled_next(enabled_q, cmd);
    busy_d    = gcm_busy_next(busy_q, cmd);
    sel_d     = gcm_sel_next(sel_req, busy_q, enabled_d, cmd);
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled_q <= 1'b0;
      busy_q    <= 1'b0;
      sel_req   <= SRC_REF;
    end else begin
      enabled_q <= enabled_d;
      busy_q    <= busy_d;
      sel_req   <= sel_d;
    end
  end

  p_park_start_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    reprog_start |=> !sel_req);
  p_park_hold_r3: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (busy_q && !reprog_done) |=> !sel_req);
  p_return_r4: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (busy_q && reprog_done && !reprog_start) |=> (sel_req == enabled_q));
  p_enable_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!busy_q && !reprog_start && en_req && !dis_req) |=> sel_req);
  p_disable_r2: assert property (@(posedge sys_clk) disable iff (!rst_n)
    dis_req |=> !sel_req);
  p_write_r5: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!busy_q && !reprog_start && !en_req && !dis_req && ns_wr)
      |=> (sel_req == $past(ns_wdata[SEL_BIT])));
endmodule

// File: rtl/gcm_top.sv
module gcm_top
  import gcm_pkg::*;
#(
  parameter int NS_W    = 32,
  parameter int SEL_BIT = 10,
  parameter int STAGES  = 2
) (
  input  logic            sys_clk,
  input  logic            rst_n,
  input  logic            ref_clk,
  input  logic            mn_clk,
  input  logic            ns_wr,
  input  logic [NS_W-1:0] ns_wdata,
  input  logic            en_req,
  input  logic            dis_req,
  input  logic            reprog_start,
  input  logic            reprog_done,
  output logic            sel_req,
  output logic            src_live,
  output logic            clk_out
);
  logic ref_gate, mn_gate;
  logic ref_gate_s, mn_gate_s;

  gcm_ctrl #(.NS_W(NS_W), .SEL_BIT(SEL_BIT)) u_ctrl (
    .sys_clk      (sys_clk),
    .rst_n        (rst_n),
    .ns_wr        (ns_wr),
    .ns_wdata     (ns_wdata),
    .en_req       (en_req),
    .dis_req      (dis_req),
    .reprog_start (reprog_start),
    .reprog_done  (reprog_done),
    .sel_req      (sel_req)
  );

  gcm_leg #(.STAGES(STAGES)) u_ref_leg (
    .src_clk (ref_clk),
    .arst_n  (rst_n),
    .pick    (sel_req == SRC_REF),
    .peer_on (mn_gate),
    .gate_on (ref_gate)
  );

  gcm_leg #(.STAGES(STAGES)) u_mn_leg (
    .src_clk (mn_clk),
    .arst_n  (rst_n),
    .pick    (sel_req == SRC_MN),
    .peer_on (ref_gate),
    .gate_on (mn_gate)
  );

  assign clk_out = (ref_clk & ref_gate) | (mn_clk & mn_gate);

  gcm_sync #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_ref_stat (
    .clk (sys_clk), .rst_n (rst_n), .d (ref_gate), .q (ref_gate_s)
  );
  gcm_sync #(.STAGES(STAGES), .RESET_VAL(1'b0)) u_mn_stat (
    .clk (sys_clk), .rst_n (rst_n), .d (mn_gate), .q (mn_gate_s)
  );

  // status follows the gate that is confirmed open; holds when none is
  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)          src_live <= SRC_REF;
    else if (mn_gate_s)  src_live <= SRC_MN;
    else if (ref_gate_s) src_live <= SRC_REF;
  end

  p_excl_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !(ref_gate && mn_gate));
  p_live_mn_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(src_live) |-> $past(mn_gate_s));
  p_live_ref_r7: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $fell(src_live) |-> $past(ref_gate_s));
endmodule

// File: tb/tb_gcm_top.sv
`timescale 1ns/1ps
module tb_gcm_top;
  localparam int  NS_W    = 32;
  localparam int  SEL_BIT = 10;
  localparam real REF_H   = 7.0;
  localparam real MN_H    = 11.0;
  localparam real MIN_PH  = (REF_H < MN_H) ? REF_H : MN_H;

  logic sys_clk = 0, rst_n = 0, ref_clk = 0, mn_clk = 0;
  logic ns_wr = 0, en_req = 0, dis_req = 0, reprog_start = 0, reprog_done = 0;
  logic [NS_W-1:0] ns_wdata = '0;
  logic sel_req, src_live, clk_out;
  bit   mn_run = 1, glitch_on = 0, armed = 0, wd = 0;
  int   total = 0, bad = 0, runts = 0, edges = 0;
  realtime last_t = 0;

  gcm_top #(.NS_W(NS_W), .SEL_BIT(SEL_BIT), .STAGES(2)) dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .ref_clk(ref_clk), .mn_clk(mn_clk),
    .ns_wr(ns_wr), .ns_wdata(ns_wdata), .en_req(en_req), .dis_req(dis_req),
    .reprog_start(reprog_start), .reprog_done(reprog_done),
    .sel_req(sel_req), .src_live(src_live), .clk_out(clk_out));

  always #4 sys_clk = ~sys_clk;
  always #(REF_H) ref_clk = ~ref_clk;
  initial forever begin
    if (mn_run) begin #(MN_H) mn_clk = 1; #(MN_H) mn_clk = 0; end
    else #1;
  end

  // phase width monitor (R8)
  always @(clk_out) begin
    if (armed && ($realtime - last_t) < MIN_PH - 0.001) runts++;
    last_t = $realtime;
    armed  = glitch_on;
  end
  always @(posedge clk_out) edges++;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cmd(bit s, bit d, bit e, bit x, bit w, logic [NS_W-1:0] wd_v);
    @(negedge sys_clk);
    reprog_start = s; reprog_done = d; en_req = e; dis_req = x;
    ns_wr = w; ns_wdata = wd_v;
    @(negedge sys_clk);
    reprog_start = 0; reprog_done = 0; en_req = 0; dis_req = 0; ns_wr = 0;
    ns_wdata = '0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic run_all();
    int e0;
    repeat (10) @(negedge sys_clk);
    rst_n = 1;
    settle(60);
    glitch_on = 1;
    chk("R1 sel after reset", sel_req, 0);
    chk("R1 live after reset", src_live, 0);
    e0 = edges; settle(20);
    chk("R1 output toggles", int'(edges > e0), 1);

    cmd(0,0,1,0,0,'0); chk("R2 enable", sel_req, 1);
    settle(60);        chk("R6 live mn", src_live, 1);
    cmd(0,0,0,1,0,'0); chk("R2 disable", sel_req, 0);
    settle(60);        chk("R6 live ref", src_live, 0);
    cmd(0,0,1,1,0,'0); chk("R2 dis wins", sel_req, 0);

    cmd(0,0,0,0,1,32'h0000_0400); chk("R5 write bit10 set", sel_req, 1);
    cmd(0,0,0,0,1,32'hFFFF_FBFF); chk("R5 other bits ignored", sel_req, 0);
    cmd(0,0,1,0,1,32'h0000_0000); chk("R5 en beats write", sel_req, 1);
    settle(60);                   chk("R6 live mn again", src_live, 1);

    cmd(1,0,0,0,0,'0); chk("R3 park on start", sel_req, 0);
    cmd(0,0,1,0,0,'0); chk("R3 en ignored while parked", sel_req, 0);
    cmd(0,0,0,0,1,32'h0000_0400); chk("R3 write ignored while parked", sel_req, 0);
    settle(60);        chk("R3 parked on reference", src_live, 0);
    cmd(0,1,0,0,0,'0); chk("R4 return when enabled", sel_req, 1);
    settle(60);        chk("R4 live mn after return", src_live, 1);
    cmd(1,0,0,0,0,'0); chk("R3 park again", sel_req, 0);
    cmd(0,0,0,1,0,'0); chk("R3 dis while parked", sel_req, 0);
    cmd(0,1,0,0,0,'0); chk("R4 stay on ref when disabled", sel_req, 0);
    settle(60);        chk("R4 live ref", src_live, 0);

    for (int k = 0; k < 12; k++) begin
      cmd(0,0,1,0,0,'0); settle(40 + k);
      chk("R6 sweep to mn", src_live, 1);
      cmd(0,0,0,1,0,'0); settle(40 + k);
      chk("R6 sweep to ref", src_live, 0);
    end

    mn_run = 0; settle(10);
    cmd(0,0,1,0,0,'0); chk("R7 select stopped source", sel_req, 1);
    settle(100);       chk("R7 live unchanged", src_live, 0);
    e0 = edges; settle(50);
    chk("R7 output held low", edges - e0, 0);
    cmd(0,0,0,1,0,'0); settle(60);
    chk("R9 live ref after recover", src_live, 0);
    e0 = edges; settle(20);
    chk("R9 output toggles again", int'(edges > e0), 1);
    mn_run = 1;
    cmd(0,0,1,0,0,'0); settle(60);
    chk("R9 mn usable again", src_live, 1);

    chk("R8 no runt phases", runts, 0);
  endtask

  initial begin
    fork
      run_all();
      begin #2_000_000; wd = 1; end
    join_any
    disable fork;
    if (wd) chk("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule